// File: doc/BRIEF.md
# Driver Fault Qualification and Over-Current Retry Controller

This block sits between the raw protection comparators of a bank of output drivers and the gate logic of those drivers. Each raw input is sampled only on cycles where a shared timebase tick is high. It must stay asserted for a programmed number of consecutive ticks before it is turned into a sticky status flag. Two kinds of fault are watched per driver: over-current and open-load. Two are watched for the whole bank: temperature warning and thermal shutdown. All flags stay set until software sends a clear-status strobe. The serial front end is expected to issue that strobe at the end of the frame that carried the command.

A qualified over-current takes its driver's enable away. When the driver's recovery-enable bit is clear, the driver stays off until the clear-status strobe arrives. When that bit is set, the driver enters a retry loop of `RETRY_TICKS` ticks and is let through for the last few ticks of each loop. This gives a pulsed soft-start current for loads with high inrush. The on-window is `ON_SHORT` ticks when the duty-select input is 0 (about 12%) and `ON_LONG` ticks when it is 1 (about 25%). A thermal shutdown removes every enable until it is cleared. Open-load and temperature warning only report; they never touch an enable. All pins are plain level signals: no data stream passes through the block, so it has no valid/ready handshake.

Top module: `fault_protect_ctrl`

## Requirements
- R1: Once reset is released, every status flag reads 0 and every bit of `drv_en` reads 1.
- R2: `oc_flag[i]` becomes 1 in the cycle after the `OC_TICKS`-th consecutive tick on which `oc_raw[i]` was sampled high. A tick that samples it low resets the count to zero, and the flag then stays 1 until cleared.
- R3: While `oc_flag[i]` is 1 and no retry window is open, `drv_en[i]` is 0. A driver whose over-current flag is 0 is enabled unless thermal shutdown is set.
- R4: `ol_flag[i]` becomes 1 after `OL_TICKS` consecutive high ticks of `ol_raw[i]`, and `tw_flag` after `TH_TICKS` consecutive high ticks of `tw_raw`. Neither flag ever changes `drv_en`.
- R5: `tsd_flag` becomes 1 after `TH_TICKS` consecutive high ticks of `tsd_raw`. While it is 1, all of `drv_en` is 0, even after `tsd_raw` returns low.
- R6: A cycle with `clr_stat` high clears every flag, every qualification count and every retry count in the next cycle. A clear takes priority over a flag that would be set in the same cycle.
- R7: The retry loop starts with its count at 0 when the over-current flag is set, and the count advances once per tick, modulo `RETRY_TICKS`. If the loop is armed, `drv_en[i]` is 1 while the count is at least `RETRY_TICKS` minus the window length. The window length is `ON_SHORT` with `duty_sel`=0 and `ON_LONG` with `duty_sel`=1.
- R8: `rcv_en[i]` is captured when the flag is set and again at each loop wrap. Clearing it in the middle of a loop still lets that loop's on-window run, but no later window opens.
- R9: Raw inputs have no effect on cycles without a tick. While `oc_flag[i]` is 1, `oc_raw[i]` is ignored, so a retry pulse is not cut short by the overload it drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase strobe; raw inputs and retry counts advance only on it |
| oc_raw | input | N_DRV | Raw over-current comparator per driver |
| ol_raw | input | N_DRV | Raw open-load comparator per driver |
| tw_raw | input | 1 | Raw temperature-warning comparator |
| tsd_raw | input | 1 | Raw thermal-shutdown comparator |
| rcv_en | input | N_DRV | Over-current auto-retry enable per driver |
| duty_sel | input | 1 | Retry on-window select: 0 short, 1 long |
| clr_stat | input | 1 | Clear-all-status strobe, one cycle |
| oc_flag | output | N_DRV | Sticky over-current flags |
| ol_flag | output | N_DRV | Sticky open-load flags |
| tw_flag | output | 1 | Sticky temperature-warning flag |
| tsd_flag | output | 1 | Sticky thermal-shutdown flag |
| drv_en | output | N_DRV | Per-driver permission to conduct |

## Verification
The bench targets several corner cases.
- A fault that drops for a single tick one count short of qualifying. A filter that failed to restart would latch a spurious flag.
- A clear that arrives on the same tick a flag would qualify. Giving the set priority would leave the flag stuck.
- Long runs of raw faults held high with no tick at all. These catch any filter that counts clock cycles instead of ticks.
- The retry loop at both window lengths, counted tick by tick, and the recovery bit dropped in the middle of a loop. A design that looked at the bit live would lose the remaining window; one that never re-sampled it would keep pulsing forever.

// File: rtl/drvprot_pkg.sv
package drvprot_pkg;

  // Length of the retry on-window in ticks for the given duty selection.
  function automatic int win_ticks(input logic long_sel, input int short_t, input int long_t);
    return long_sel ? long_t : short_t;
  endfunction

endpackage

// File: rtl/dp_fault_qual.sv
// Tick-based persistence filter feeding a sticky flag.
module dp_fault_qual #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  input  logic clr,
  output logic flag
);
  localparam int CW = (LEN > 1) ? $clog2(LEN + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (tick && !flag) begin
      if (!raw) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        cnt  <= '0;
        flag <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dp_oc_retry.sv
// Per-driver over-current retry loop: decides whether the over-current
// state still allows the driver to conduct.
module dp_oc_retry #(
  parameter int RETRY_TICKS = 8,
  parameter int ON_SHORT    = 1,
  parameter int ON_LONG     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  input  logic oc_flag,
  input  logic rcv_en,
  input  logic duty_sel,
  output logic oc_ok
);
  import drvprot_pkg::*;

  localparam int PW = (RETRY_TICKS > 1) ? $clog2(RETRY_TICKS) : 1;
  localparam logic [PW-1:0] WRAP = PW'(RETRY_TICKS - 1);

  logic [PW-1:0] phase;
  logic          armed;
  logic          in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      armed <= 1'b0;
    end else if (clr || !oc_flag) begin
      phase <= '0;
      armed <= rcv_en;
    end else if (tick) begin
      if (phase == WRAP) begin
        phase <= '0;
        armed <= rcv_en;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_comb begin
    in_win = int'(phase) >= (RETRY_TICKS - win_ticks(duty_sel, ON_SHORT, ON_LONG));
    oc_ok  = !oc_flag || (armed && in_win);
  end
endmodule

// File: rtl/dp_gate.sv
// Final enable combine: thermal shutdown overrides every driver.
module dp_gate #(
  parameter int N_DRV = 4
) (
  input  logic [N_DRV-1:0] oc_ok,
  input  logic             tsd_flag,
  output logic [N_DRV-1:0] drv_en
);
  always_comb begin
    drv_en = tsd_flag ? '0 : oc_ok;
  end
endmodule

// File: rtl/fault_protect_ctrl.sv
module fault_protect_ctrl #(
  parameter int N_DRV       = 4,
  parameter int OC_TICKS    = 4,
  parameter int OL_TICKS    = 12,
  parameter int TH_TICKS    = 3,
  parameter int RETRY_TICKS = 8,
  parameter int ON_SHORT    = 1,
  parameter int ON_LONG     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [N_DRV-1:0] oc_raw,
  input  logic [N_DRV-1:0] ol_raw,
  input  logic             tw_raw,
  input  logic             tsd_raw,
  input  logic [N_DRV-1:0] rcv_en,
  input  logic             duty_sel,
  input  logic             clr_stat,
  output logic [N_DRV-1:0] oc_flag,
  output logic [N_DRV-1:0] ol_flag,
  output logic             tw_flag,
  output logic             tsd_flag,
  output logic [N_DRV-1:0] drv_en
);
  logic [N_DRV-1:0] oc_ok;

  for (genvar gi = 0; gi < N_DRV; gi++) begin : g_drv
    dp_fault_qual #(.LEN(OC_TICKS)) u_ocq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .raw(oc_raw[gi]),
      .clr(clr_stat), .flag(oc_flag[gi])
    );
    dp_fault_qual #(.LEN(OL_TICKS)) u_olq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .raw(ol_raw[gi]),
      .clr(clr_stat), .flag(ol_flag[gi])
    );
    dp_oc_retry #(
      .RETRY_TICKS(RETRY_TICKS), .ON_SHORT(ON_SHORT), .ON_LONG(ON_LONG)
    ) u_rty (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr_stat),
      .oc_flag(oc_flag[gi]), .rcv_en(rcv_en[gi]), .duty_sel(duty_sel),
      .oc_ok(oc_ok[gi])
    );
  end

  dp_fault_qual #(.LEN(TH_TICKS)) u_twq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw(tw_raw),
    .clr(clr_stat), .flag(tw_flag)
  );
  dp_fault_qual #(.LEN(TH_TICKS)) u_tsdq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw(tsd_raw),
    .clr(clr_stat), .flag(tsd_flag)
  );

  dp_gate #(.N_DRV(N_DRV)) u_gate (
    .oc_ok(oc_ok), .tsd_flag(tsd_flag), .drv_en(drv_en)
  );
endmodule

// File: rtl/fault_protect_ctrl_chk.sv
module fault_protect_ctrl_chk #(
  parameter int N_DRV = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             clr_stat,
  input logic [N_DRV-1:0] oc_flag,
  input logic [N_DRV-1:0] ol_flag,
  input logic             tw_flag,
  input logic             tsd_flag,
  input logic [N_DRV-1:0] drv_en
);
  logic hist_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_ok <= 1'b0;
    else        hist_ok <= 1'b1;
  end

  assert_tsd_blocks_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_flag |-> (drv_en == '0));

  assert_clean_driver_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tsd_flag |-> ((~oc_flag & ~drv_en) == '0));

  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stat |=> (oc_flag == '0 && ol_flag == '0 && !tw_flag && !tsd_flag));

  assert_oc_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && !$past(clr_stat)) |-> (($past(oc_flag) & ~oc_flag) == '0));

  assert_flags_need_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && !$past(tick)) |->
      ($stable(oc_flag) && $stable(ol_flag) && $stable(tw_flag) && $stable(tsd_flag)) || $past(clr_stat));
endmodule

bind fault_protect_ctrl fault_protect_ctrl_chk #(.N_DRV(N_DRV)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .clr_stat(clr_stat),
  .oc_flag(oc_flag), .ol_flag(ol_flag), .tw_flag(tw_flag),
  .tsd_flag(tsd_flag), .drv_en(drv_en)
);

// File: tb/sim_fault_protect_ctrl.sv
`timescale 1ns/1ps
module sim_fault_protect_ctrl;
  localparam int N  = 4;
  localparam int OC = 4;
  localparam int OL = 12;
  localparam int TH = 3;
  localparam int P  = 8;
  localparam int S  = 1;
  localparam int L  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [N-1:0] oc_raw = '0, ol_raw = '0, rcv_en = '0;
  logic tw_raw = 1'b0, tsd_raw = 1'b0, duty_sel = 1'b0, clr_stat = 1'b0;
  logic [N-1:0] oc_flag, ol_flag, drv_en;
  logic tw_flag, tsd_flag;

  always #10 clk = ~clk;

  fault_protect_ctrl #(.N_DRV(N), .OC_TICKS(OC), .OL_TICKS(OL), .TH_TICKS(TH),
    .RETRY_TICKS(P), .ON_SHORT(S), .ON_LONG(L)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .oc_raw(oc_raw), .ol_raw(ol_raw),
    .tw_raw(tw_raw), .tsd_raw(tsd_raw), .rcv_en(rcv_en), .duty_sel(duty_sel),
    .clr_stat(clr_stat), .oc_flag(oc_flag), .ol_flag(ol_flag), .tw_flag(tw_flag),
    .tsd_flag(tsd_flag), .drv_en(drv_en));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // ---------------- behavioural reference model ----------------
  int m_occ[N], m_oc[N], m_olc[N], m_ol[N], m_rc[N], m_arm[N];
  int m_twc, m_tw, m_tsdc, m_tsd;

  task automatic qstep(input bit raw, input int len, inout int c, inout int f);
    if (f == 0) begin
      if (!raw) c = 0;
      else if (c + 1 == len) begin c = 0; f = 1; end
      else c = c + 1;
    end
  endtask

  task automatic model_step();
    if (!rst_n) begin
      foreach (m_oc[i]) begin
        m_occ[i] = 0; m_oc[i] = 0; m_olc[i] = 0; m_ol[i] = 0; m_rc[i] = 0; m_arm[i] = 0;
      end
      m_twc = 0; m_tw = 0; m_tsdc = 0; m_tsd = 0;
    end else if (clr_stat) begin
      foreach (m_oc[i]) begin
        m_occ[i] = 0; m_oc[i] = 0; m_olc[i] = 0; m_ol[i] = 0; m_rc[i] = 0;
        m_arm[i] = int'(rcv_en[i]);
      end
      m_twc = 0; m_tw = 0; m_tsdc = 0; m_tsd = 0;
    end else begin
      foreach (m_oc[i]) begin
        if (m_oc[i] == 0) begin
          m_rc[i] = 0; m_arm[i] = int'(rcv_en[i]);
        end else if (tick) begin
          m_rc[i] = m_rc[i] + 1;
          if (m_rc[i] == P) begin m_rc[i] = 0; m_arm[i] = int'(rcv_en[i]); end
        end
      end
      if (tick) begin
        foreach (m_oc[i]) begin
          qstep(oc_raw[i], OC, m_occ[i], m_oc[i]);
          qstep(ol_raw[i], OL, m_olc[i], m_ol[i]);
        end
        qstep(tw_raw, TH, m_twc, m_tw);
        qstep(tsd_raw, TH, m_tsdc, m_tsd);
      end
    end
  endtask

  function automatic bit exp_en(input int i);
    int w;
    w = duty_sel ? L : S;
    if (m_tsd != 0) return 1'b0;
    if (m_oc[i] == 0) return 1'b1;
    return (m_arm[i] != 0) && (m_rc[i] >= P - w);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Model advances on each edge; outputs compared mid-high-phase.
  always @(posedge clk) begin
    model_step();
    #5;
    if (rst_n && !finished) begin
      logic [N-1:0] e_oc, e_ol, e_en;
      for (int i = 0; i < N; i++) begin
        e_oc[i] = (m_oc[i] != 0); e_ol[i] = (m_ol[i] != 0); e_en[i] = exp_en(i);
      end
      chk("R2", "model oc_flag", int'(oc_flag), int'(e_oc));
      chk("R4", "model ol_flag", int'(ol_flag), int'(e_ol));
      chk("R4", "model tw_flag", int'(tw_flag), m_tw);
      chk("R5", "model tsd_flag", int'(tsd_flag), m_tsd);
      chk("R7", "model drv_en", int'(drv_en), int'(e_en));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask
  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) do_tick();
  endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask
  task automatic clear();
    @(negedge clk) clr_stat = 1'b1;
    @(negedge clk) clr_stat = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    int cnt;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1", "oc_flag after reset", int'(oc_flag), 0);
    chk("R1", "drv_en after reset", int'(drv_en), 4'hF);
    chk("R1", "tsd_flag after reset", int'(tsd_flag), 0);

    // R9: raw high without ticks does nothing
    oc_raw = 4'hF; tsd_raw = 1'b1;
    idle(30);
    chk("R9", "oc_flag with no tick", int'(oc_flag), 0);
    chk("R9", "tsd_flag with no tick", int'(tsd_flag), 0);
    oc_raw = '0; tsd_raw = 1'b0;

    // R2 qualification on driver 0
    oc_raw[0] = 1'b1;
    ticks(OC - 1);
    chk("R2", "oc_flag one tick short", int'(oc_flag[0]), 0);
    ticks(1);
    chk("R2", "oc_flag qualified", int'(oc_flag[0]), 1);
    chk("R3", "drv_en locked off", int'(drv_en[0]), 0);
    oc_raw[0] = 1'b0;
    ticks(2 * P);
    chk("R3", "still locked without recovery", int'(drv_en[0]), 0);
    chk("R3", "other drivers enabled", int'(drv_en[3:1]), 3'h7);

    // R2 gap resets count on driver 1
    oc_raw[1] = 1'b1; ticks(OC - 1);
    oc_raw[1] = 1'b0; ticks(1);
    oc_raw[1] = 1'b1; ticks(OC - 1);
    chk("R2", "gap restarted filter", int'(oc_flag[1]), 0);
    oc_raw[1] = 1'b0; ticks(1);

    // R6 clear restores driver
    clear();
    chk("R6", "oc_flag cleared", int'(oc_flag), 0);
    chk("R6", "drv_en restored", int'(drv_en), 4'hF);

    // R6 clear beats set in the same cycle
    oc_raw[2] = 1'b1; ticks(OC - 1);
    @(negedge clk) begin tick = 1'b1; clr_stat = 1'b1; end
    @(negedge clk) begin tick = 1'b0; clr_stat = 1'b0; end
    chk("R6", "clear wins over set", int'(oc_flag[2]), 0);
    ticks(OC - 1);
    chk("R6", "count restarted after clear", int'(oc_flag[2]), 0);
    oc_raw[2] = 1'b0; clear();

    // R4 informational flags
    ol_raw[3] = 1'b1; tw_raw = 1'b1;
    ticks(OL);
    chk("R4", "ol_flag set", int'(ol_flag[3]), 1);
    chk("R4", "tw_flag set", int'(tw_flag), 1);
    chk("R4", "drv_en untouched", int'(drv_en), 4'hF);
    ol_raw = '0; tw_raw = 1'b0; clear();

    // R5 thermal shutdown
    tsd_raw = 1'b1; ticks(TH);
    chk("R5", "tsd_flag set", int'(tsd_flag), 1);
    chk("R5", "all drivers off", int'(drv_en), 0);
    tsd_raw = 1'b0; ticks(5);
    chk("R5", "off after raw gone", int'(drv_en), 0);
    clear();
    chk("R5", "drivers back after clear", int'(drv_en), 4'hF);

    // R7 retry, short window
    rcv_en[0] = 1'b1; duty_sel = 1'b0; oc_raw[0] = 1'b1;
    ticks(OC);
    chk("R7", "flag set in retry mode", int'(oc_flag[0]), 1);
    cnt = 0;
    for (int k = 0; k < 2 * P; k++) begin do_tick(); if (drv_en[0]) cnt++; end
    chk("R7", "short window tick count", cnt, 2 * S);
    chk("R9", "flag held during pulses", int'(oc_flag[0]), 1);
    oc_raw[0] = 1'b0; clear();

    // R7 retry, long window
    duty_sel = 1'b1; oc_raw[0] = 1'b1;
    ticks(OC);
    cnt = 0;
    for (int k = 0; k < 2 * P; k++) begin do_tick(); if (drv_en[0]) cnt++; end
    chk("R7", "long window tick count", cnt, 2 * L);
    oc_raw[0] = 1'b0; clear();

    // R8 recovery bit dropped mid-loop
    duty_sel = 1'b0; oc_raw[1] = 1'b1; rcv_en[1] = 1'b1;
    ticks(OC);
    ticks(3);
    rcv_en[1] = 1'b0;
    cnt = 0;
    for (int k = 0; k < 2 * P - 3; k++) begin do_tick(); if (drv_en[1]) cnt++; end
    chk("R8", "one trailing retry window", cnt, S);
    oc_raw[1] = 1'b0; rcv_en = '0; clear();
    idle(4);

    summary();
  end
endmodule